// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit performs lane-parallel integer arithmetic on a 32-bit word. A width selector splits both operands into four unsigned bytes, two signed halfwords or one signed word. A function code then picks one operation for every lane: wrapping or clamping add, wrapping or clamping subtract, clamping absolute value, or halving add/subtract with or without rounding. Each lane works on its own. The packed result is registered and appears one clock after the request.

Any lane that overflows in an add, subtract or absolute-value operation sets one shared overflow flag. The flag is sticky. Later arithmetic never lowers it, and it falls only when the clear input is pulsed. Software can run a whole block of operations and then test a single bit to learn whether any result was clamped or wrapped.

Top module: `packed_sat_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit resets `out_valid`, `out_res` and `ovf_flag` to 0.
- R2: A request with `in_valid` high at a clock edge produces `out_res` and raises `out_valid` after that edge. With `in_valid` low, `out_valid` is low after the edge and `out_res` holds its value.
- R3: The `in_width` codes are: 0 = four unsigned 8-bit lanes, 1 = two signed 16-bit lanes, 2 = one signed 32-bit lane. Lane k occupies bits [k*W+W-1 : k*W]. Code 3 is reserved: it returns 0 and never flags.
- R4: The `in_fn` codes are: 0 wrap add, 1 clamp add, 2 wrap sub, 3 clamp sub, 4 clamp abs, 5 halve add, 6 halve add rounded, 7 halve sub, 8 halve sub rounded. Codes 9 to 15 return 0 and never flag.
- R5: A wrap add or wrap sub returns the lane result modulo 2^W. It flags on signed overflow in signed lanes, and on a carry or borrow out of the lane in unsigned lanes.
- R6: On overflow, a clamp add or clamp sub in a signed lane returns the positive maximum when the first operand is non-negative, and the negative minimum otherwise. It also flags.
- R7: On overflow, a clamp add in an unsigned lane returns all ones and a clamp sub returns zero. Both flag.
- R8: Clamp abs treats every lane as signed, byte lanes included. It returns the magnitude. The most negative lane value returns the positive maximum and flags.
- R9: A halving operation computes the exact sum or difference, adds 1 for the rounded codes, and shifts right by one (arithmetic in signed lanes). It keeps the low W bits and never flags.
- R10: Lanes compute and clamp independently. After an accepted request, the flag is set if any lane overflowed.
- R11: Once set, `ovf_flag` stays set until `clr_ovf` is high at an edge. A clear in the same cycle as an overflowing request leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_fn | input | 4 | Operation code |
| in_width | input | 2 | Lane width and signedness selector |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| clr_ovf | input | 1 | One-cycle clear of the sticky flag |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Registered packed result |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a clear pulse arriving in the same cycle as an overflowing lane, because the two inputs pull the flag in opposite directions. The bench asserts the clear together with every operation in its sweeps. Every overflow in the sweep therefore exercises the collision, and every non-overflowing operation exercises the plain clear. Operand lanes draw from the boundary values of each width (zero, one, extremes and their neighbours) mixed with scattered values, so the most-negative abs and both clamp directions occur in every lane position.

// File: rtl/packed_sat_alu_pkg.sv
// Shared codes for the packed saturating add/subtract unit.
// Assumes a 4-bit function code and a 2-bit width selector.
package packed_sat_alu_pkg;

    typedef enum logic [3:0] {
        FN_ADD      = 4'd0,
        FN_ADD_SAT  = 4'd1,
        FN_SUB      = 4'd2,
        FN_SUB_SAT  = 4'd3,
        FN_ABS_SAT  = 4'd4,
        FN_HADD     = 4'd5,
        FN_HADD_RND = 4'd6,
        FN_HSUB     = 4'd7,
        FN_HSUB_RND = 4'd8
    } alu_fn_e;

    typedef enum logic [1:0] {
        WD_BYTE = 2'd0,
        WD_HALF = 2'd1,
        WD_WORD = 2'd2,
        WD_RSV  = 2'd3
    } alu_width_e;

endpackage

// File: rtl/packed_sat_lane.sv
// One arithmetic lane of width W.
// Computes the selected operation combinationally and reports lane overflow.
// Assumes W >= 2. IS_SIGNED picks two's-complement or unsigned treatment for
// add/sub/halving. Abs always treats the lane as signed.
module packed_sat_lane
    import packed_sat_alu_pkg::*;
#(
    parameter int W         = 8,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONES  = {W{1'b1}};
    localparam logic [W-1:0] ZERO  = '0;

    logic [W:0]   a_x, b_x, sum_x, dif_x, half_src, half_t;
    logic         add_ovf, sub_ovf, rnd;
    logic [W-1:0] clamp_s, abs_mag, half_res;

    // Extended operands and the shared arithmetic terms.
    always_comb begin
        a_x      = IS_SIGNED ? {a[W-1], a} : {1'b0, a};
        b_x      = IS_SIGNED ? {b[W-1], b} : {1'b0, b};
        sum_x    = a_x + b_x;
        dif_x    = a_x - b_x;
        add_ovf  = IS_SIGNED ? (sum_x[W] ^ sum_x[W-1]) : sum_x[W];
        sub_ovf  = IS_SIGNED ? (dif_x[W] ^ dif_x[W-1]) : dif_x[W];
        clamp_s  = a[W-1] ? S_MIN : S_MAX;
        abs_mag  = a[W-1] ? (~a + 1'b1) : a;
        rnd      = (fn == FN_HADD_RND) || (fn == FN_HSUB_RND);
        half_src = ((fn == FN_HSUB) || (fn == FN_HSUB_RND)) ? dif_x : sum_x;
        half_t   = half_src + {{W{1'b0}}, rnd};
        half_res = W'(half_t >> 1);
    end

    // Select the lane result and overflow for the function code.
    always_comb begin
        res = ZERO;
        ovf = 1'b0;
        case (fn)
            FN_ADD: begin
                res = sum_x[W-1:0];
                ovf = add_ovf;
            end
            FN_ADD_SAT: begin
                ovf = add_ovf;
                res = add_ovf ? (IS_SIGNED ? clamp_s : ONES) : sum_x[W-1:0];
            end
            FN_SUB: begin
                res = dif_x[W-1:0];
                ovf = sub_ovf;
            end
            FN_SUB_SAT: begin
                ovf = sub_ovf;
                res = sub_ovf ? (IS_SIGNED ? clamp_s : ZERO) : dif_x[W-1:0];
            end
            FN_ABS_SAT: begin
                ovf = (a == S_MIN);
                res = (a == S_MIN) ? S_MAX : abs_mag;
            end
            FN_HADD, FN_HADD_RND, FN_HSUB, FN_HSUB_RND: begin
                res = half_res;
            end
            default: begin
                res = ZERO;
                ovf = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/packed_sat_lane_array.sv
// Splits a WORD_W-bit word into WORD_W/LANE_W lanes of one kind.
// Returns the packed result and the OR of all lane overflows.
// Assumes LANE_W divides WORD_W.
module packed_sat_lane_array #(
    parameter int WORD_W    = 32,
    parameter int LANE_W    = 8,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [3:0]        fn,
    output logic [WORD_W-1:0] res,
    output logic              ovf_any
);
    localparam int N_LANES = WORD_W / LANE_W;

    logic [N_LANES-1:0] lane_ovf;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        packed_sat_lane #(
            .W         (LANE_W),
            .IS_SIGNED (IS_SIGNED)
        ) lane_i (
            .a   (a[k*LANE_W +: LANE_W]),
            .b   (b[k*LANE_W +: LANE_W]),
            .fn  (fn),
            .res (res[k*LANE_W +: LANE_W]),
            .ovf (lane_ovf[k])
        );
    end

    // Any overflowing lane raises the group overflow.
    always_comb ovf_any = |lane_ovf;

endmodule

// File: rtl/packed_sat_alu.sv
// Packed saturating add/subtract unit: top level.
// Three lane arrays (unsigned bytes, signed halves, signed word) run in
// parallel. The width selector picks one, and the result is registered.
// A sticky flag collects lane overflow until it is cleared.
// Assumes WORD_W is a multiple of 32.
module packed_sat_alu
    import packed_sat_alu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_fn,
    input  logic [1:0]        in_width,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              clr_ovf,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res,
    output logic              ovf_flag
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int FULL_W = 32;

    logic [WORD_W-1:0] res_b, res_h, res_w, sel_res;
    logic              ovf_b, ovf_h, ovf_w, sel_ovf;

    packed_sat_lane_array #(.WORD_W(WORD_W), .LANE_W(BYTE_W), .IS_SIGNED(1'b0)) arr_byte_i (
        .a(in_a), .b(in_b), .fn(in_fn), .res(res_b), .ovf_any(ovf_b)
    );
    packed_sat_lane_array #(.WORD_W(WORD_W), .LANE_W(HALF_W), .IS_SIGNED(1'b1)) arr_half_i (
        .a(in_a), .b(in_b), .fn(in_fn), .res(res_h), .ovf_any(ovf_h)
    );
    packed_sat_lane_array #(.WORD_W(WORD_W), .LANE_W(FULL_W), .IS_SIGNED(1'b1)) arr_word_i (
        .a(in_a), .b(in_b), .fn(in_fn), .res(res_w), .ovf_any(ovf_w)
    );

    // Choose the lane array named by the width selector.
    always_comb begin
        case (in_width)
            WD_BYTE: begin sel_res = res_b; sel_ovf = ovf_b; end
            WD_HALF: begin sel_res = res_h; sel_ovf = ovf_h; end
            WD_WORD: begin sel_res = res_w; sel_ovf = ovf_w; end
            default: begin sel_res = '0;    sel_ovf = 1'b0;  end
        endcase
    end

    // Register the result, the valid strobe and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= sel_res;
            end
            ovf_flag <= (ovf_flag & ~clr_ovf) | (in_valid & sel_ovf);
        end
    end

endmodule

// File: rtl/packed_sat_alu_chk.sv
// Property checker for packed_sat_alu, attached with bind.
// Observes ports only.
module packed_sat_alu_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_fn,
    input logic [1:0]        in_width,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              clr_ovf,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_res,
    input logic              ovf_flag
);
    logic halving;
    // Flag requests whose code is one of the halving operations.
    always_comb halving = (in_fn >= 4'd5) && (in_fn <= 4'd8);

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_res))); // R2
    AST_RSV_WIDTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_width == 2'd3) |=> (out_res == '0)); // R3
    AST_RSV_FN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fn > 4'd8) |=> (out_res == '0)); // R4
    AST_HALVE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && halving && !ovf_flag) |=> !ovf_flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag); // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !in_valid) |=> !ovf_flag); // R11

endmodule

bind packed_sat_alu packed_sat_alu_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/packed_sat_alu_tb_top.sv
`timescale 1ns/1ps
module packed_sat_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_fn = '0;
    logic [1:0]  in_width = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        clr_ovf = 1'b0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        ovf_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    packed_sat_alu #(.WORD_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fn(in_fn),
        .in_width(in_width), .in_a(in_a), .in_b(in_b), .clr_ovf(clr_ovf),
        .out_valid(out_valid), .out_res(out_res), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Boundary values first, scattered values after.
    function automatic longint unsigned pick(input int idx, input int w);
        longint unsigned mask = (64'd1 << w) - 1;
        longint unsigned half = 64'd1 << (w - 1);
        case (idx)
            0: return 0;
            1: return 1;
            2: return half - 1;
            3: return half;
            4: return mask;
            5: return half + 1;
            6: return half - 2;
            7: return 2;
            default: return ((longint'(idx) * 64'd2654435761) ^ (longint'(idx) * 64'd40503 << 5)) & mask;
        endcase
    endfunction

    // Arithmetic model of one lane.
    task automatic lane_model(input int fn, input int w, input bit sgn,
                              input longint unsigned ua, input longint unsigned ub,
                              output longint unsigned r, output bit o);
        longint mx_s = (longint'(1) << (w - 1)) - 1;
        longint mn_s = -(longint'(1) << (w - 1));
        longint mx_u = (longint'(1) << w) - 1;
        longint sa = (ua > longint'(mx_s)) ? longint'(ua) - (longint'(1) << w) : longint'(ua);
        longint sb = (ub > longint'(mx_s)) ? longint'(ub) - (longint'(1) << w) : longint'(ub);
        longint va = sgn ? sa : longint'(ua);
        longint vb = sgn ? sb : longint'(ub);
        longint t = 0;
        o = 1'b0;
        case (fn)
            0, 1: begin
                t = va + vb;
                o = sgn ? (t > mx_s || t < mn_s) : (t > mx_u);
                if (fn == 1 && o) t = sgn ? ((t > mx_s) ? mx_s : mn_s) : mx_u;
            end
            2, 3: begin
                t = va - vb;
                o = sgn ? (t > mx_s || t < mn_s) : (t < 0);
                if (fn == 3 && o) t = sgn ? ((t > mx_s) ? mx_s : mn_s) : 0;
            end
            4: begin
                t = (sa < 0) ? -sa : sa;
                if (t > mx_s) begin t = mx_s; o = 1'b1; end
            end
            5, 6: t = (va + vb + ((fn == 6) ? 1 : 0)) >>> 1;
            7, 8: t = (va - vb + ((fn == 8) ? 1 : 0)) >>> 1;
            default: t = 0;
        endcase
        r = longint'(t) & mx_u;
    endtask

    task automatic word_model(input int fn, input int wd, input logic [31:0] a,
                              input logic [31:0] b, output logic [31:0] r, output bit o);
        r = '0;
        o = 1'b0;
        if (wd != 3) begin
            int w = 8 << wd;
            for (int k = 0; k < 32 / w; k++) begin
                longint unsigned lr;
                bit lo;
                lane_model(fn, w, wd != 0, (longint'(a) >> (k * w)) & ((64'd1 << w) - 1),
                           (longint'(b) >> (k * w)) & ((64'd1 << w) - 1), lr, lo);
                r = r | 32'(lr << (k * w));
                o = o | lo;
            end
        end
    endtask

    function automatic string tag_of(input int fn, input int wd);
        if (wd == 3) return "R3";
        if (fn > 8) return "R4";
        if (fn == 0 || fn == 2) return "R5";
        if (fn == 1 || fn == 3) return (wd == 0) ? "R7" : "R6";
        if (fn == 4) return "R8";
        return "R9";
    endfunction

    task automatic run_op(input int fn, input int wd, input logic [31:0] a,
                          input logic [31:0] b, input bit clr);
        @(negedge clk);
        in_valid = 1'b1; in_fn = 4'(fn); in_width = 2'(wd);
        in_a = a; in_b = b; clr_ovf = clr;
        @(negedge clk);
        in_valid = 1'b0; clr_ovf = 1'b0;
    endtask

    initial begin
        logic [31:0] er;
        bit eo;
        repeat (3) @(negedge clk);
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R1", "out_res after reset", out_res, 32'd0);
        check("R1", "ovf_flag after reset", 32'(ovf_flag), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Sweep: the clear rides with every request, so the flag shows this op only.
        for (int wd = 0; wd < 4; wd++) begin
            for (int fn = 0; fn < 16; fn++) begin
                int lim = (wd == 3 || fn > 8) ? 1 : 16;
                for (int i = 0; i < lim; i++) begin
                    for (int j = 0; j < 16; j++) begin
                        logic [31:0] a = '0, b = '0;
                        int w = (wd == 3) ? 32 : (8 << wd);
                        for (int k = 0; k < 32 / w; k++) begin
                            a = a | 32'(pick((i + k) % 16, w) << (k * w));
                            b = b | 32'(pick((j + 3 * k) % 16, w) << (k * w));
                        end
                        run_op(fn, wd, a, b, 1'b1);
                        word_model(fn, wd, a, b, er, eo);
                        check(tag_of(fn, wd), "lane result", out_res, er);
                        check("R2", "out_valid after request", 32'(out_valid), 32'd1);
                        check("R10", "flag with same-cycle clear (R11)", 32'(ovf_flag), 32'(eo));
                    end
                end
            end
        end

        // One overflowing byte lane among quiet ones.
        run_op(1, 0, 32'h1020_30FF, 32'h0101_0101, 1'b1);
        check("R10", "one lane clamps, others add", out_res, 32'h1121_31FF);
        check("R10", "single lane sets flag", 32'(ovf_flag), 32'd1);
        run_op(0, 0, 32'h0000_0000, 32'h0000_0000, 1'b0);
        check("R11", "flag survives quiet op", 32'(ovf_flag), 32'd1);
        check("R5", "quiet wrap add", out_res, 32'd0);
        repeat (3) @(negedge clk);
        check("R2", "out_valid idle", 32'(out_valid), 32'd0);
        check("R2", "out_res held idle", out_res, 32'd0);
        check("R11", "flag held idle", 32'(ovf_flag), 32'd1);
        @(negedge clk); clr_ovf = 1'b1;
        @(negedge clk); clr_ovf = 1'b0;
        check("R11", "flag after clear", 32'(ovf_flag), 32'd0);
        run_op(4, 2, 32'h8000_0000, 32'h0, 1'b0);
        check("R8", "abs of word minimum", out_res, 32'h7FFF_FFFF);
        check("R8", "abs minimum flags", 32'(ovf_flag), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule